// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual page number into a physical page number by fetching one page table entry from memory. The entry sits at a flat table base plus the virtual page number times the entry size in bytes. Software writes the table base through a write port, and does so again each time it switches to another process's table. A consumer presents one request at a time with a page number, a page offset and an access type. The walker issues one read on a ready/valid memory port and waits for the entry. It then checks the valid bit and the access rights, and returns one response carrying a status, the physical page number and the unchanged offset.

Faults are reported, not resolved. A missing mapping returns a page-fault status. An access that the rights field forbids returns a protection-fault status. In both cases the physical page number is zero.

Top module: `ptw_walker`

## Requirements
- R1: While reset is high and in the first cycle after it, `req_ready` is 1, and `resp_valid` and `mem_rd_valid` are 0.
- R2: Each accepted request causes exactly one memory read, at address base + vpn*PTE_BYTES (PTE_BYTES defaults to 4). `mem_rd_valid` and `mem_rd_addr` hold steady until `mem_rd_ready` is seen high.
- R3: `req_ready` is 0 from the cycle after a request is accepted until the response has been given. `resp_valid` is high for exactly one cycle per request.
- R4: The entry layout is bit 0 valid, bits 2:1 rights, and bits PPN_W+2:3 physical page number. If the valid bit is 0, the status is 1 (page fault) and `resp_ppn` is 0, whatever the rights field holds.
- R5: The rights codes are 0 none, 1 read-only, 2 read/write and 3 read/execute. The access codes are 0 read, 1 write and 2 fetch. An access that the rights do not permit gives status 2 (protection fault) and `resp_ppn` 0.
- R6: A valid entry whose rights permit the access gives status 0, with `resp_ppn` equal to the entry's page number field.
- R7: `resp_off` equals the offset of the request, in every status.
- R8: A base write is used from the next accepted request onward. A base write made while a walk is in progress does not change that walk's read address.
- R9: Access code 3 is reserved and always gives status 2 with `resp_ppn` 0, even on a valid read/write or read/execute entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr_en | input | 1 | Write strobe for the table base register |
| base_wr_data | input | ADDR_W | New table base value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vpn | input | VPN_W | Virtual page number |
| req_off | input | OFF_W | Page offset |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_status | output | 2 | 0 ok, 1 page fault, 2 protection fault |
| resp_ppn | output | PPN_W | Physical page number, zero on a fault |
| resp_off | output | OFF_W | Offset returned unchanged |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | ADDR_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data present |
| mem_rsp_data | input | PTE_W | Fetched entry |

## Verification
The case that is hardest to reach is a base write that lands inside a walk. From outside, it can only be seen through which entry the walk reads. The stimulus fills the same page number with different page numbers under two bases. It writes the new base in the cycle after acceptance, while the memory holds off `mem_rd_ready` for several cycles. The walk in progress must still return the entry under the old base, and the next request must return the entry under the new base. The memory model also stalls its ready and delays its data, so the bench sees the held address and counts exactly one read per response.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        RGT_NONE = 2'd0,
        RGT_RO   = 2'd1,
        RGT_RW   = 2'd2,
        RGT_RX   = 2'd3
    } rights_e;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_PGFLT = 2'd1,
        ST_PROT  = 2'd2
    } status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_CHECK,
        S_RESPOND
    } walk_state_e;

    function automatic logic rights_allow(rights_e r, acc_e a);
        logic ok;
        case (r)
            RGT_RO:  ok = (a == ACC_READ);
            RGT_RW:  ok = (a == ACC_READ) || (a == ACC_WRITE);
            RGT_RX:  ok = (a == ACC_READ) || (a == ACC_FETCH);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/ptw_addr_calc.sv
module ptw_addr_calc #(
    parameter int ADDR_W    = 32,
    parameter int VPN_W     = 20,
    parameter int PTE_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VPN_W-1:0]  vpn,
    output logic [ADDR_W-1:0] addr
);
    localparam int SHIFT = $clog2(PTE_BYTES);

    logic [ADDR_W-1:0] vpn_ext;
    assign vpn_ext = ADDR_W'(vpn);
    assign addr    = base + (vpn_ext << SHIFT);
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
#(
    parameter int PPN_W = 20
) (
    input  logic             valid,
    input  logic [1:0]       rights,
    input  logic [PPN_W-1:0] ppn_in,
    input  logic [1:0]       acc,
    output logic [1:0]       status,
    output logic [PPN_W-1:0] ppn_out
);
    always_comb begin
        if (!valid) begin
            status  = ST_PGFLT;
            ppn_out = '0;
        end else if (!rights_allow(rights_e'(rights), acc_e'(acc))) begin
            status  = ST_PROT;
            ppn_out = '0;
        end else begin
            status  = ST_OK;
            ppn_out = ppn_in;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int VPN_W     = 20,
    parameter int PPN_W     = 20,
    parameter int OFF_W     = 12,
    parameter int PTE_BYTES = 4,
    parameter int PTE_W     = PPN_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_wr_en,
    input  logic [ADDR_W-1:0] base_wr_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              resp_valid,
    output logic [1:0]        resp_status,
    output logic [PPN_W-1:0]  resp_ppn,
    output logic [OFF_W-1:0]  resp_off,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [PTE_W-1:0]  mem_rsp_data
);
    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic [1:0]       rights;
        logic             valid;
    } pte_t;

    walk_state_e       state_q;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] walk_base_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [OFF_W-1:0]  off_q;
    logic [1:0]        acc_q;
    pte_t              pte_q;
    logic [1:0]        status_q;
    logic [PPN_W-1:0]  ppn_q;

    logic [1:0]        chk_status;
    logic [PPN_W-1:0]  chk_ppn;

    ptw_addr_calc #(
        .ADDR_W   (ADDR_W),
        .VPN_W    (VPN_W),
        .PTE_BYTES(PTE_BYTES)
    ) addr_i (
        .base(walk_base_q),
        .vpn (vpn_q),
        .addr(mem_rd_addr)
    );

    ptw_perm_check #(
        .PPN_W(PPN_W)
    ) perm_i (
        .valid  (pte_q.valid),
        .rights (pte_q.rights),
        .ppn_in (pte_q.ppn),
        .acc    (acc_q),
        .status (chk_status),
        .ppn_out(chk_ppn)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (base_wr_en) begin
            base_q <= base_wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            walk_base_q <= '0;
            vpn_q       <= '0;
            off_q       <= '0;
            acc_q       <= '0;
            pte_q       <= '0;
            status_q    <= '0;
            ppn_q       <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        walk_base_q <= base_q;
                        vpn_q       <= req_vpn;
                        off_q       <= req_off;
                        acc_q       <= req_acc;
                        state_q     <= S_ISSUE;
                    end
                end
                S_ISSUE: begin
                    if (mem_rd_ready) begin
                        state_q <= S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (mem_rsp_valid) begin
                        pte_q   <= pte_t'(mem_rsp_data);
                        state_q <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    status_q <= chk_status;
                    ppn_q    <= chk_ppn;
                    state_q  <= S_RESPOND;
                end
                default: begin
                    state_q <= S_IDLE;
                end
            endcase
        end
    end

    assign req_ready    = (state_q == S_IDLE);
    assign mem_rd_valid = (state_q == S_ISSUE);
    assign resp_valid   = (state_q == S_RESPOND);
    assign resp_status  = status_q;
    assign resp_ppn     = ppn_q;
    assign resp_off     = off_q;

    // R2
    mem_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    // R2
    mem_req_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rd_valid) |-> $past(req_valid && req_ready));

    // R3
    resp_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    // R3
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid || mem_rd_valid) |-> !req_ready);

    // R4
    fault_zero_ppn_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_status != 2'd0) |-> (resp_ppn == '0));

    // R6
    status_legal_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_status != 2'd3));
endmodule

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
    localparam int ADDR_W = 32;
    localparam int VPN_W  = 20;
    localparam int PPN_W  = 20;
    localparam int OFF_W  = 12;
    localparam int PTE_W  = PPN_W + 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              base_wr_en = 1'b0;
    logic [ADDR_W-1:0] base_wr_data = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [VPN_W-1:0]  req_vpn = '0;
    logic [OFF_W-1:0]  req_off = '0;
    logic [1:0]        req_acc = '0;
    logic              resp_valid;
    logic [1:0]        resp_status;
    logic [PPN_W-1:0]  resp_ppn;
    logic [OFF_W-1:0]  resp_off;
    logic              mem_rd_valid;
    logic              mem_rd_ready = 1'b1;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic              mem_rsp_valid = 1'b0;
    logic [PTE_W-1:0]  mem_rsp_data = '0;

    always #5 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst(rst),
        .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_off(req_off), .req_acc(req_acc),
        .resp_valid(resp_valid), .resp_status(resp_status),
        .resp_ppn(resp_ppn), .resp_off(resp_off),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    typedef struct {
        logic [1:0]       status;
        logic [PPN_W-1:0] ppn;
        logic [OFF_W-1:0] off;
        string            tag;
    } exp_t;

    exp_t              exp_q[$];
    logic [PTE_W-1:0]  mem [logic [ADDR_W-1:0]];
    logic [ADDR_W-1:0] base_model = '0;
    int compared = 0;
    int mismatched = 0;
    int reads_seen = 0;
    int resps_seen = 0;
    int stall_left = 0;
    int rsp_lat = 1;
    int pend_cnt = 0;
    bit cap_flag = 0;
    logic [ADDR_W-1:0] cap_addr = '0;
    int cycles = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [PTE_W-1:0] mem_rd(input logic [ADDR_W-1:0] a);
        if (mem.exists(a)) return mem[a];
        return '0;
    endfunction

    task automatic set_pte(input logic [ADDR_W-1:0] b, input logic [VPN_W-1:0] v,
                           input bit vld, input logic [1:0] r, input logic [PPN_W-1:0] p);
        mem[b + ADDR_W'(v) * 4] = {p, r, vld};
    endtask

    function automatic bit allowed(input logic [1:0] r, input logic [1:0] a);
        return (r == 2'd1 && a == 2'd0) ||
               (r == 2'd2 && (a == 2'd0 || a == 2'd1)) ||
               (r == 2'd3 && (a == 2'd0 || a == 2'd2));
    endfunction

    task automatic write_base(input logic [ADDR_W-1:0] d);
        @(negedge clk);
        base_wr_en = 1'b1;
        base_wr_data = d;
        base_model = d;
        @(negedge clk);
        base_wr_en = 1'b0;
    endtask

    task automatic send(input logic [VPN_W-1:0] v, input logic [OFF_W-1:0] o,
                        input logic [1:0] a, input bit mid_wr,
                        input logic [ADDR_W-1:0] new_base, input string tag);
        logic [PTE_W-1:0] e;
        exp_t x;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e = mem_rd(base_model + ADDR_W'(v) * 4);
        x.off = o;
        x.tag = tag;
        if (!e[0]) begin
            x.status = 2'd1; x.ppn = '0;
        end else if (!allowed(e[2:1], a)) begin
            x.status = 2'd2; x.ppn = '0;
        end else begin
            x.status = 2'd0; x.ppn = e[PTE_W-1:3];
        end
        exp_q.push_back(x);
        req_valid = 1'b1; req_vpn = v; req_off = o; req_acc = a;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b0, {"R3 busy ", tag}, req_ready, 0);
        if (mid_wr) begin
            base_wr_en = 1'b1; base_wr_data = new_base; base_model = new_base;
            @(negedge clk);
            base_wr_en = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (!rst && mem_rd_valid && mem_rd_ready) begin
            cap_flag = 1;
            cap_addr = mem_rd_addr;
            reads_seen++;
        end
    end

    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (cap_flag) begin
            cap_flag = 0;
            pend_cnt = rsp_lat;
        end
        if (pend_cnt > 0) begin
            pend_cnt--;
            if (pend_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data = mem_rd(cap_addr);
            end
        end
        if (mem_rd_valid && stall_left > 0) stall_left--;
        mem_rd_ready = (stall_left == 0);
    end

    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            exp_t x;
            resps_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected response", 1, 0);
            end else begin
                x = exp_q.pop_front();
                check(resp_status == x.status, {"R4/R5/R6 status ", x.tag}, resp_status, x.status);
                check(resp_ppn == x.ppn, {"R6 ppn ", x.tag}, resp_ppn, x.ppn);
                check(resp_off == x.off, {"R7 off ", x.tag}, resp_off, x.off);
                check(reads_seen == resps_seen, {"R2 one read ", x.tag}, reads_seen, resps_seen);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    localparam logic [ADDR_W-1:0] B0 = 32'h1000_0000;
    localparam logic [ADDR_W-1:0] B1 = 32'h2000_4000;

    initial begin
        set_pte(B0, 20'h00001, 1, 2'd1, 20'hAAAA1);
        set_pte(B0, 20'h00002, 1, 2'd2, 20'hBBBB2);
        set_pte(B0, 20'h00003, 1, 2'd3, 20'hCCCC3);
        set_pte(B0, 20'h00004, 1, 2'd0, 20'hDDDD4);
        set_pte(B0, 20'h00005, 0, 2'd2, 20'hEEEE5);
        set_pte(B0, 20'h00000, 1, 2'd2, 20'h12345);
        set_pte(B0, 20'hFFFFF, 1, 2'd3, 20'hFEDCB);
        set_pte(B0, 20'h00077, 1, 2'd2, 20'h0A0A0);
        set_pte(B1, 20'h00077, 1, 2'd2, 20'h0B0B0);

        repeat (2) @(negedge clk);
        // R1
        check(req_ready == 1'b1, "R1 req_ready in reset", req_ready, 1);
        check(resp_valid == 1'b0, "R1 resp_valid in reset", resp_valid, 0);
        check(mem_rd_valid == 1'b0, "R1 mem_rd_valid in reset", mem_rd_valid, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && !resp_valid && !mem_rd_valid, "R1 after reset",
              {req_ready, resp_valid, mem_rd_valid}, 3'b100);

        write_base(B0);
        // R6 R7 ok cases
        send(20'h00001, 12'h123, 2'd0, 0, '0, "R6 read ro");
        send(20'h00002, 12'hFFF, 2'd1, 0, '0, "R6 write rw");
        send(20'h00002, 12'h000, 2'd0, 0, '0, "R6 read rw");
        send(20'h00003, 12'h5A5, 2'd2, 0, '0, "R6 fetch rx");
        send(20'h00003, 12'h001, 2'd0, 0, '0, "R6 read rx");
        // R5 protection faults
        send(20'h00001, 12'h222, 2'd1, 0, '0, "R5 write ro");
        send(20'h00001, 12'h333, 2'd2, 0, '0, "R5 fetch ro");
        send(20'h00002, 12'h444, 2'd2, 0, '0, "R5 fetch rw");
        send(20'h00003, 12'h555, 2'd1, 0, '0, "R5 write rx");
        send(20'h00004, 12'h666, 2'd0, 0, '0, "R5 read none");
        // R9 reserved access
        send(20'h00002, 12'h777, 2'd3, 0, '0, "R9 rsvd on rw");
        send(20'h00003, 12'h888, 2'd3, 0, '0, "R9 rsvd on rx");
        // R4 page faults
        send(20'h00005, 12'h999, 2'd0, 0, '0, "R4 invalid rw entry");
        send(20'h00444, 12'hABC, 2'd0, 0, '0, "R4 unmapped");
        // R2 address boundaries, with stall and latency
        send(20'h00000, 12'h010, 2'd1, 0, '0, "R2 vpn zero");
        stall_left = 5; rsp_lat = 3;
        send(20'hFFFFF, 12'hFED, 2'd2, 0, '0, "R2 vpn max stalled");
        // R8 base write during a stalled walk
        stall_left = 4; rsp_lat = 2;
        send(20'h00077, 12'h0F0, 2'd1, 1, B1, "R8 walk uses old base");
        stall_left = 0; rsp_lat = 1;
        send(20'h00077, 12'h0F1, 2'd0, 0, '0, "R8 next uses new base");
        write_base(B0);
        send(20'h00077, 12'h0F2, 2'd0, 0, '0, "R8 back to first base");

        repeat (5) @(negedge clk);
        check(resp_valid == 1'b0 && req_ready == 1'b1, "R3 idle at end",
              {resp_valid, req_ready}, 2'b01);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule